// File: doc/BRIEF.md
# Prioritized Interrupt Request/Service Tracker

This block tracks pending and in-service interrupts across a vector space of 256 entries. Three bitmaps are kept: pending requests, vectors in service, and the trigger kind recorded for each vector. A source accepts a vector with a flag that marks it edge or level. The block offers the best pending vector to the core through a valid/acknowledge handshake. On the acknowledge cycle it moves that vector from pending to in-service.

A numerically larger vector ranks higher. A pending vector is offered when interrupts are enabled and either nothing is in service or it outranks the highest vector in service. A higher vector can therefore preempt a running one without waiting for its end-of-interrupt. An end-of-interrupt strobe retires the highest vector in service. If that vector was accepted as level-triggered, a one-cycle broadcast pulse carries its number. Each vector can hold one queued instance beside one in service, and further arrivals merge into the queued one.

Top module: `irq_tracker`

## Requirements
- R1: After reset all three bitmaps are clear: `disp_valid` and `bcast_valid` are 0 until a vector is accepted.
- R2: An accepted vector (`acc_valid`=1, `acc_vec`>=16) becomes pending. Repeated arrivals for a vector that is already pending merge into one request, which is dispatched once.
- R3: `disp_valid` is 1 only while `int_en`=1 and some vector is pending. `disp_vec` then shows the numerically highest pending vector.
- R4: The cycle with `disp_valid`=1 and `disp_ack`=1 clears that vector from pending and sets it in service. Without an acknowledge nothing moves, and an acknowledged vector is not offered again unless it arrives again.
- R5: While vectors are in service, a pending vector is offered only if it is numerically greater than the highest in-service vector (preemption). An equal or lower one waits.
- R6: An `eoi` pulse clears the highest in-service vector. Pending vectors are then offered again under the rule of R5, so a preempted vector resumes ranking after the preempting one retires.
- R7: On acceptance the vector's trigger bit is set for `acc_level`=1 and cleared for `acc_level`=0. An `eoi` that retires a vector whose trigger bit is set raises `bcast_valid` for exactly the next cycle, with `bcast_vec` equal to that vector. Edge vectors produce no pulse.
- R8: An `eoi` while nothing is in service changes no state and produces no broadcast.
- R9: Vectors 0 to 15 are reserved. Accepting one has no effect and it is never dispatched.
- R10: If a vector is accepted in the same cycle as its own acknowledge, the new arrival stays pending.
- R11: A vector may be pending and in service at once. The pending copy is not offered until the in-service copy retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Accept an interrupt this cycle |
| acc_vec | input | 8 | Vector being accepted |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| int_en | input | 1 | Core has interrupts enabled |
| disp_valid | output | 1 | A vector is offered to the core |
| disp_vec | output | 8 | Offered vector |
| disp_ack | input | 1 | Core takes the offered vector |
| eoi | input | 1 | End of interrupt for the highest in-service vector |
| bcast_valid | output | 1 | One-cycle EOI broadcast for a level vector |
| bcast_vec | output | 8 | Vector being broadcast |

## Verification
The bench targets the cycle where a vector is accepted while its own earlier copy is being acknowledged. A design that lets the clear win there loses an interrupt. It also checks a pending vector equal to the one in service, which a design using >= instead of > would dispatch twice while nested. The bench sends EOIs with nothing in service, where a careless design broadcasts a stale vector. It accepts reserved vectors, which a design that fails to mask them would dispatch. A long random run over a narrow vector range keeps preemption, nesting and level/edge changes colliding so that bitmap and pulse errors show up.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NVEC = 256;
  localparam int unsigned VW   = $clog2(NVEC);
  localparam int unsigned RSVD = 16;
  typedef logic [VW-1:0] vec_t;

  // Preemption rule: pending outranks in-service, or nothing is in service.
  function automatic logic outranks(input logic req_any, input vec_t req_top,
                                    input logic isr_any, input vec_t isr_top);
    return req_any && (!isr_any || (req_top > isr_top));
  endfunction
endpackage

// File: rtl/irq_lod.sv
// Leading-one detector built as groups, then a pick of the top active group.
module irq_lod #(
  parameter int unsigned W = 256,
  parameter int unsigned G = 16
) (
  input  logic [W-1:0]         bits,
  output logic                 any,
  output logic [$clog2(W)-1:0] idx
);
  localparam int unsigned NG  = W / G;
  localparam int unsigned GW  = $clog2(G);
  localparam int unsigned NGW = $clog2(NG);

  logic [NG-1:0] grp_any;
  logic [GW-1:0] grp_idx [NG];

  function automatic logic [GW-1:0] local_msb(input logic [G-1:0] v);
    logic [GW-1:0] r;
    r = '0;
    for (int i = 0; i < int'(G); i++)
      if (v[i]) r = GW'(i);
    return r;
  endfunction

  for (genvar g = 0; g < int'(NG); g++) begin : g_grp
    assign grp_any[g] = |bits[g*G +: G];
    assign grp_idx[g] = local_msb(bits[g*G +: G]);
  end

  logic [NGW-1:0] gsel;
  always_comb begin
    gsel = '0;
    for (int i = 0; i < int'(NG); i++)
      if (grp_any[i]) gsel = NGW'(i);
  end

  assign any = |grp_any;
  assign idx = {gsel, grp_idx[gsel]};
endmodule

// File: rtl/irq_bitmaps.sv
// Pending, in-service and trigger-kind bitmaps with their update rules.
module irq_bitmaps
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_fire,
  input  vec_t            acc_vec,
  input  logic            acc_level,
  input  logic            mv_fire,
  input  vec_t            mv_vec,
  input  logic            ret_fire,
  input  vec_t            ret_vec,
  output logic [NVEC-1:0] req_bits,
  output logic [NVEC-1:0] isr_bits,
  output logic [NVEC-1:0] tmr_bits
);
  logic [NVEC-1:0] acc_oh, mv_oh, ret_oh;
  assign acc_oh = acc_fire ? (NVEC'(1) << acc_vec) : '0;
  assign mv_oh  = mv_fire  ? (NVEC'(1) << mv_vec)  : '0;
  assign ret_oh = ret_fire ? (NVEC'(1) << ret_vec) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_bits <= '0;
      isr_bits <= '0;
      tmr_bits <= '0;
    end else begin
      // a new arrival wins over the clear of the vector being acknowledged
      req_bits <= (req_bits & ~mv_oh) | acc_oh;
      isr_bits <= (isr_bits & ~ret_oh) | mv_oh;
      tmr_bits <= acc_level ? (tmr_bits | acc_oh) : (tmr_bits & ~acc_oh);
    end
  end
endmodule

// File: rtl/irq_tracker.sv
module irq_tracker
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic [7:0] acc_vec,
  input  logic       acc_level,
  input  logic       int_en,
  output logic       disp_valid,
  output logic [7:0] disp_vec,
  input  logic       disp_ack,
  input  logic       eoi,
  output logic       bcast_valid,
  output logic [7:0] bcast_vec
);
  logic [NVEC-1:0] req_bits, isr_bits, tmr_bits;
  logic            req_any, isr_any;
  vec_t            req_top, isr_top;

  // named internal events
  logic acc_fire, mv_fire, ret_fire, bc_fire;
  assign acc_fire = acc_valid && (acc_vec >= vec_t'(RSVD));
  assign mv_fire  = disp_valid && disp_ack;
  assign ret_fire = eoi && isr_any;
  assign bc_fire  = ret_fire && tmr_bits[isr_top];

  irq_bitmaps u_maps (
    .clk(clk), .rst_n(rst_n),
    .acc_fire(acc_fire), .acc_vec(acc_vec), .acc_level(acc_level),
    .mv_fire(mv_fire), .mv_vec(req_top),
    .ret_fire(ret_fire), .ret_vec(isr_top),
    .req_bits(req_bits), .isr_bits(isr_bits), .tmr_bits(tmr_bits)
  );

  irq_lod #(.W(NVEC)) u_req_lod (.bits(req_bits), .any(req_any), .idx(req_top));
  irq_lod #(.W(NVEC)) u_isr_lod (.bits(isr_bits), .any(isr_any), .idx(isr_top));

  assign disp_valid = int_en && outranks(req_any, req_top, isr_any, isr_top);
  assign disp_vec   = req_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcast_valid <= 1'b0;
      bcast_vec   <= '0;
    end else begin
      bcast_valid <= bc_fire;
      if (bc_fire) bcast_vec <= isr_top;
    end
  end
endmodule

// File: rtl/irq_tracker_chk.sv
module irq_tracker_chk
  import irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            int_en,
  input logic            eoi,
  input logic            disp_valid,
  input logic [7:0]      disp_vec,
  input logic            bcast_valid,
  input logic            mv_fire,
  input logic            acc_fire,
  input logic [7:0]      acc_vec,
  input logic            isr_any,
  input vec_t            isr_top,
  input logic [NVEC-1:0] req_bits
);
  p_valid_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> int_en);
  p_no_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_vec >= 8'(RSVD)));
  p_preempt_rank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && isr_any) |-> (disp_vec > isr_top));
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_fire && !(acc_fire && acc_vec == disp_vec)) |=> !req_bits[$past(disp_vec)]);
  p_same_cycle_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_fire && acc_fire && acc_vec == disp_vec) |=> req_bits[$past(disp_vec)]);
  p_bcast_from_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |-> $past(eoi));
  p_empty_eoi_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !isr_any) |=> !bcast_valid);
endmodule

bind irq_tracker irq_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .int_en(int_en), .eoi(eoi),
  .disp_valid(disp_valid), .disp_vec(disp_vec), .bcast_valid(bcast_valid),
  .mv_fire(mv_fire), .acc_fire(acc_fire), .acc_vec(acc_vec),
  .isr_any(isr_any), .isr_top(isr_top), .req_bits(req_bits)
);

// File: tb/tb_irq_tracker.sv
`timescale 1ns/1ps
module tb_irq_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 0, acc_level = 0, int_en = 0, disp_ack = 0, eoi = 0;
  logic [7:0] acc_vec = '0;
  logic       disp_valid, bcast_valid;
  logic [7:0] disp_vec, bcast_vec;

  int n_cmp = 0, n_bad = 0;
  bit [255:0] m_req, m_isr, m_tmr;
  bit         e_bc;
  bit [7:0]   e_bcv;

  always #2 clk = ~clk;

  irq_tracker dut (.*);

  function automatic int top_of(input bit [255:0] b);
    for (int i = 255; i >= 0; i--) if (b[i]) return i;
    return -1;
  endfunction

  function automatic bit offer(input bit en, input bit [255:0] rq, input bit [255:0] is);
    int rt = top_of(rq);
    int it = top_of(is);
    return en && (rt >= 0) && (rt > it);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, compare outputs against the model, advance the model
  task automatic step(input bit av, input int vec, input bit lvl, input bit ack,
                      input bit en, input bit e, input string tag);
    bit ev;
    int rt, it;
    @(negedge clk);
    acc_valid = av; acc_vec = 8'(vec); acc_level = lvl;
    disp_ack = ack; int_en = en; eoi = e;
    #1;
    ev = offer(en, m_req, m_isr);
    rt = top_of(m_req);
    it = top_of(m_isr);
    chk({tag, " R3 valid"}, int'(disp_valid), int'(ev));
    if (ev) chk({tag, " R3 vec"}, int'(disp_vec), rt);
    chk({tag, " R7 bcast"}, int'(bcast_valid), int'(e_bc));
    if (e_bc) chk({tag, " R7 bvec"}, int'(bcast_vec), int'(e_bcv));
    e_bc = e && (it >= 0) && m_tmr[it];
    if (e_bc) e_bcv = 8'(it);
    if (e && it >= 0) m_isr[it] = 1'b0;
    if (ev && ack) begin m_req[rt] = 1'b0; m_isr[rt] = 1'b1; end
    if (av && vec >= 16) begin m_req[vec] = 1'b1; m_tmr[vec] = lvl; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_req = '0; m_isr = '0; m_tmr = '0; e_bc = 0; e_bcv = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    step(0, 0, 0, 1, 1, 1, "R1 reset");
    // R9: reserved vectors ignored
    step(1, 5, 1, 1, 1, 0, "R9 accept 5");
    step(1, 15, 0, 1, 1, 0, "R9 accept 15");
    step(0, 0, 0, 1, 1, 1, "R9 nothing");
    // R2: merge repeated arrivals
    step(1, 40, 0, 0, 1, 0, "R2 first");
    step(1, 40, 0, 0, 1, 0, "R2 second");
    step(0, 0, 0, 0, 0, 0, "R3 disabled");
    step(0, 0, 0, 1, 1, 0, "R4 ack 40");
    step(0, 0, 0, 1, 1, 0, "R4 no repeat");
    // R11 / R5: equal and lower wait, higher preempts
    step(1, 40, 0, 1, 1, 0, "R11 again 40");
    step(1, 30, 1, 1, 1, 0, "R5 lower 30");
    step(1, 100, 1, 0, 1, 0, "R5 higher 100");
    step(0, 0, 0, 1, 1, 0, "R5 ack 100");
    // R6 / R7: retire level 100, then edge 40
    step(0, 0, 0, 0, 1, 1, "R7 eoi 100");
    step(0, 0, 0, 0, 1, 1, "R6 eoi 40");
    // R10: accept 40 in its own acknowledge cycle
    step(1, 40, 0, 1, 1, 0, "R10 ack+acc 40");
    step(0, 0, 0, 1, 1, 1, "R10 eoi 40");
    step(0, 0, 0, 1, 1, 0, "R10 ack pending 40");
    step(0, 0, 0, 0, 1, 1, "R6 eoi 40b");
    step(0, 0, 0, 1, 1, 0, "R6 ack 30");
    step(0, 0, 0, 0, 1, 1, "R7 eoi 30");
    // R8: empty eoi
    step(0, 0, 0, 0, 1, 1, "R8 empty eoi");
    step(0, 0, 0, 0, 1, 1, "R8 empty eoi2");
    step(0, 0, 0, 0, 1, 0, "R8 after");
    // random phase over a narrow range to force collisions
    void'($urandom(32'h1234));
    for (int k = 0; k < 4000; k++) begin
      int v = 8 + int'($urandom_range(0, 31));
      step(($urandom_range(0, 2) == 0), v, $urandom_range(0, 1) == 1,
           ($urandom_range(0, 1) == 1), ($urandom_range(0, 7) != 0),
           ($urandom_range(0, 3) == 0), "rand R2 R4 R5 R6");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule